// File: doc/BRIEF.md
# Exact-Match Receive Address Filter

This block keeps a small table of unicast station addresses and decides, for every received frame, whether the destination address equals one of them. Software loads each entry through a word-wide write port in two steps: a 32-bit low word and then a high word. Only the high-word write makes the new address live. The entry becomes valid on that write only when the whole 48-bit address is non-zero. A compare strobe with a 48-bit destination address returns, one cycle later, a qualified result: hit or miss, and the index of the lowest matching entry.

Entry 0 holds the station's primary address. An initialisation pulse loads the primary address into entry 0 and empties every other entry. At boot, a loader can fetch an alternate address from a word-addressed non-volatile store over a request/acknowledge port. The loader first reads a pointer word. If the pointer is absent, or if the address it points to is a multicast address, entry 0 keeps its contents. Otherwise the alternate address replaces entry 0.

Addresses on the compare and station ports are in network order: bits 47:40 carry the first byte on the wire (byte 0) and bits 7:0 carry byte 5.

Top module: `rx_addr_filter`

## Requirements
- R1: A low-word write places address byte 0 in data bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24.
- R2: A high-word write places address byte 4 in data bits 7:0 and byte 5 in bits 15:8. Data bits 31:16 are ignored. The valid flag is derived by the block.
- R3: An entry becomes valid on a high-word write only if the combined 48-bit address is non-zero. An all-zero entry never produces a hit, not even for an all-zero compare address.
- R4: A low-word write on its own leaves the compared address of that entry unchanged. The staged low word takes effect at the next high-word write to the same entry.
- R5: An init pulse loads the station address into entry 0 and makes every other entry invalid.
- R6: hit_valid_o is high exactly in the cycle after a cmp_valid_i cycle. On a miss, hit_o is 0 and hit_idx_o is 0.
- R7: When several valid entries match, hit_idx_o reports the lowest index.
- R8: The loader reads the pointer word at address PTR_WORD. A pointer value of 0x0000 or 0xFFFF ends the load with entry 0 unchanged.
- R9: The alternate address is read as three words from consecutive addresses, starting at the pointer. When alt_func1_i is high, FUNC1_OFS is added to the pointer first. In each word, bits 7:0 are the earlier byte and bits 15:8 the later byte. An accepted address replaces entry 0.
- R10: An alternate address whose byte 0 has bit 0 set (a multicast address) leaves entry 0 unchanged.
- R11: nvm_req_o stays high, with nvm_addr_o stable, until nvm_ack_i is seen. nvm_data_i is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load station address into entry 0, clear the rest |
| station_addr_i | input | 48 | Primary station address, network order |
| wr_en_i | input | 1 | Register word write strobe |
| wr_hi_i | input | 1 | 1 selects high word, 0 low word |
| wr_idx_i | input | IDX_W | Entry index of the write |
| wr_data_i | input | 32 | Write data |
| cmp_valid_i | input | 1 | Compare strobe |
| cmp_addr_i | input | 48 | Destination address to compare, network order |
| hit_valid_o | output | 1 | Compare result valid |
| hit_o | output | 1 | Some valid entry matched |
| hit_idx_o | output | IDX_W | Lowest matching entry |
| alt_start_i | input | 1 | Start alternate address load |
| alt_func1_i | input | 1 | Select second-port pointer offset |
| alt_done_o | output | 1 | Load finished pulse |
| nvm_req_o | output | 1 | Store read request |
| nvm_addr_o | output | 16 | Store word address |
| nvm_ack_i | input | 1 | Store read acknowledge, data valid |
| nvm_data_i | input | 16 | Store read data |

## Verification
The assertions assume that nvm_ack_i comes only while nvm_req_o is high and lasts one cycle. They also assume that alt_start_i is not pulsed while a load is running, and that wr_idx_i stays below NUM_ENTRIES. The stimulus keeps to these assumptions. Its store model acknowledges each request once, after a fixed delay, and drops the acknowledge on the next cycle. It waits for alt_done_o before it starts another load. Its random writes draw indices only from the table's range. Random compares mostly reuse addresses already written, so that hits, shadowed duplicates and zero entries occur often.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  typedef logic [47:0] mac_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_PTR,
    LD_WORD,
    LD_FINISH
  } ld_state_e;

  // low/high register words -> network-order address
  function automatic mac_t words_to_mac(input logic [31:0] lo, input logic [15:0] hi);
    return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
  endfunction

endpackage

// File: rtl/rxaf_entry_bank.sv
module rxaf_entry_bank
  import rxaf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned IDX_W       = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         init_i,
  input  logic [47:0]                  station_addr_i,
  input  logic                         alt_wr_i,
  input  logic [47:0]                  alt_addr_i,
  input  logic                         wr_en_i,
  input  logic                         wr_hi_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [31:0]                  wr_lo_data_i,
  input  logic [15:0]                  wr_hi_data_i,
  output logic [NUM_ENTRIES-1:0][47:0] addr_o,
  output logic [NUM_ENTRIES-1:0]       valid_o
);

  logic [NUM_ENTRIES-1:0][31:0] stage_q;
  mac_t                         hi_commit_addr;

  assign hi_commit_addr = words_to_mac(stage_q[wr_idx_i], wr_hi_data_i);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    localparam bit IsPrimary = (g == 0);
    logic sel;
    mac_t new_addr;

    assign sel      = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign new_addr = words_to_mac(stage_q[g], wr_hi_data_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
        addr_o[g]  <= '0;
        valid_o[g] <= 1'b0;
      end else if (init_i) begin
        stage_q[g] <= '0;
        addr_o[g]  <= IsPrimary ? station_addr_i : '0;
        valid_o[g] <= IsPrimary ? (|station_addr_i) : 1'b0;
      end else if (IsPrimary && alt_wr_i) begin
        addr_o[g]  <= alt_addr_i;
        valid_o[g] <= |alt_addr_i;
      end else if (sel) begin
        if (wr_hi_i) begin
          addr_o[g]  <= new_addr;
          valid_o[g] <= |new_addr;
        end else begin
          stage_q[g] <= wr_lo_data_i;
        end
      end
    end
  end

  a_r3_zero_commit_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i && !init_i && !(alt_wr_i && wr_idx_i == '0) && hi_commit_addr == '0)
    |=> !valid_o[$past(wr_idx_i)]);

  a_r4_low_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i && !init_i && !alt_wr_i)
    |=> addr_o[$past(wr_idx_i)] == $past(addr_o[wr_idx_i]));

  a_r5_init_clears_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (valid_o >> 1) == '0);

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned IDX_W       = 4
) (
  input  logic [NUM_ENTRIES-1:0][47:0] addr_i,
  input  logic [NUM_ENTRIES-1:0]       valid_i,
  input  logic [47:0]                  cmp_addr_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);

  logic [NUM_ENTRIES-1:0] match;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (addr_i[g] == cmp_addr_i);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rxaf_alt_loader.sv
module rxaf_alt_loader
  import rxaf_pkg::*;
#(
  parameter logic [15:0] PTR_WORD  = 16'h0037,
  parameter logic [15:0] FUNC1_OFS = 16'h0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        func1_i,
  output logic        nvm_req_o,
  output logic [15:0] nvm_addr_o,
  input  logic        nvm_ack_i,
  input  logic [15:0] nvm_data_i,
  output logic        alt_wr_o,
  output logic [47:0] alt_addr_o,
  output logic        done_o
);

  ld_state_e   state_q;
  logic [15:0] rd_addr_q;
  logic [1:0]  cnt_q;
  logic        func1_q;
  logic        found_q;
  mac_t        bytes_q;
  logic        no_ptr;

  assign no_ptr = (nvm_data_i == 16'h0000) || (nvm_data_i == 16'hFFFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LD_IDLE;
      rd_addr_q <= '0;
      cnt_q     <= '0;
      func1_q   <= 1'b0;
      found_q   <= 1'b0;
      bytes_q   <= '0;
    end else begin
      unique case (state_q)
        LD_IDLE: if (start_i) begin
          state_q   <= LD_PTR;
          rd_addr_q <= PTR_WORD;
          func1_q   <= func1_i;
          found_q   <= 1'b0;
        end
        LD_PTR: if (nvm_ack_i) begin
          if (no_ptr) begin
            state_q <= LD_FINISH;
          end else begin
            state_q   <= LD_WORD;
            rd_addr_q <= nvm_data_i + (func1_q ? FUNC1_OFS : 16'h0000);
            cnt_q     <= '0;
            found_q   <= 1'b1;
          end
        end
        LD_WORD: if (nvm_ack_i) begin
          unique case (cnt_q)
            2'd0:    bytes_q[47:32] <= {nvm_data_i[7:0], nvm_data_i[15:8]};
            2'd1:    bytes_q[31:16] <= {nvm_data_i[7:0], nvm_data_i[15:8]};
            default: bytes_q[15:0]  <= {nvm_data_i[7:0], nvm_data_i[15:8]};
          endcase
          if (cnt_q == 2'd2) begin
            state_q <= LD_FINISH;
          end else begin
            cnt_q     <= cnt_q + 2'd1;
            rd_addr_q <= rd_addr_q + 16'd1;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign nvm_req_o  = (state_q == LD_PTR) || (state_q == LD_WORD);
  assign nvm_addr_o = rd_addr_q;
  assign done_o     = (state_q == LD_FINISH);
  // byte 0 bit 0 is the group bit
  assign alt_wr_o   = done_o && found_q && !bytes_q[40];
  assign alt_addr_o = bytes_q;

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nvm_req_o && !nvm_ack_i) |=> (nvm_req_o && $stable(nvm_addr_o)));

  a_r8_no_ptr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LD_PTR && nvm_ack_i && no_ptr) |=> !alt_wr_o);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter logic [15:0] PTR_WORD    = 16'h0037,
  parameter logic [15:0] FUNC1_OFS   = 16'h0003,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [47:0]      station_addr_i,
  input  logic             wr_en_i,
  input  logic             wr_hi_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  input  logic             cmp_valid_i,
  input  logic [47:0]      cmp_addr_i,
  output logic             hit_valid_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  input  logic             alt_start_i,
  input  logic             alt_func1_i,
  output logic             alt_done_o,
  output logic             nvm_req_o,
  output logic [15:0]      nvm_addr_o,
  input  logic             nvm_ack_i,
  input  logic [15:0]      nvm_data_i
);

  logic [NUM_ENTRIES-1:0][47:0] ent_addr;
  logic [NUM_ENTRIES-1:0]       ent_valid;
  logic                         alt_wr;
  logic [47:0]                  alt_addr;
  logic                         cmb_hit;
  logic [IDX_W-1:0]             cmb_idx;
  logic                         unused_hi_bits;

  assign unused_hi_bits = ^wr_data_i[31:16];

  rxaf_alt_loader #(
    .PTR_WORD (PTR_WORD),
    .FUNC1_OFS(FUNC1_OFS)
  ) u_loader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (alt_start_i),
    .func1_i   (alt_func1_i),
    .nvm_req_o (nvm_req_o),
    .nvm_addr_o(nvm_addr_o),
    .nvm_ack_i (nvm_ack_i),
    .nvm_data_i(nvm_data_i),
    .alt_wr_o  (alt_wr),
    .alt_addr_o(alt_addr),
    .done_o    (alt_done_o)
  );

  rxaf_entry_bank #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .init_i        (init_i),
    .station_addr_i(station_addr_i),
    .alt_wr_i      (alt_wr),
    .alt_addr_i    (alt_addr),
    .wr_en_i       (wr_en_i),
    .wr_hi_i       (wr_hi_i),
    .wr_idx_i      (wr_idx_i),
    .wr_lo_data_i  (wr_data_i),
    .wr_hi_data_i  (wr_data_i[15:0]),
    .addr_o        (ent_addr),
    .valid_o       (ent_valid)
  );

  rxaf_match #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_match (
    .addr_i    (ent_addr),
    .valid_i   (ent_valid),
    .cmp_addr_i(cmp_addr_i),
    .hit_o     (cmb_hit),
    .idx_o     (cmb_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      hit_idx_o   <= '0;
    end else begin
      hit_valid_o <= cmp_valid_i;
      hit_o       <= cmp_valid_i && cmb_hit;
      hit_idx_o   <= cmp_valid_i ? cmb_idx : '0;
    end
  end

  a_r6_hit_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_valid_o);

  a_r6_result_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> hit_valid_o);

  a_r6_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> !hit_valid_o);

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  localparam int unsigned N = 16;
  localparam int unsigned IW = 4;
  localparam logic [15:0] PTR = 16'h0037;
  localparam logic [15:0] OFS = 16'h0003;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic [47:0] station = '0;
  logic wr_en = 1'b0, wr_hi = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic cmp_valid = 1'b0;
  logic [47:0] cmp_addr = '0;
  logic hit_valid, hit;
  logic [IW-1:0] hit_idx;
  logic alt_start = 1'b0, alt_func1 = 1'b0, alt_done;
  logic nvm_req, nvm_ack = 1'b0;
  logic [15:0] nvm_addr, nvm_data = '0;

  int checks = 0;
  int fails = 0;

  logic [47:0] m_addr [N];
  bit          m_valid[N];
  logic [31:0] m_stage[N];
  logic [15:0] mem [64];
  logic [15:0] rd_log [8];
  int          rd_cnt = 0;
  int          lat = 0;

  always #10 clk = ~clk;

  rx_addr_filter #(.NUM_ENTRIES(N), .PTR_WORD(PTR), .FUNC1_OFS(OFS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .station_addr_i(station),
    .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .cmp_valid_i(cmp_valid), .cmp_addr_i(cmp_addr),
    .hit_valid_o(hit_valid), .hit_o(hit), .hit_idx_o(hit_idx),
    .alt_start_i(alt_start), .alt_func1_i(alt_func1), .alt_done_o(alt_done),
    .nvm_req_o(nvm_req), .nvm_addr_o(nvm_addr), .nvm_ack_i(nvm_ack), .nvm_data_i(nvm_data)
  );

  // store model: fixed latency, one-cycle acknowledge
  always @(negedge clk) begin
    if (nvm_ack) begin
      nvm_ack = 1'b0;
    end else if (nvm_req) begin
      if (lat == 2) begin
        lat = 0;
        nvm_ack = 1'b1;
        nvm_data = mem[nvm_addr[5:0]];
        if (rd_cnt < 8) rd_log[rd_cnt] = nvm_addr;
        rd_cnt++;
      end else begin
        lat++;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(input logic [47:0] a);
    return {a[23:16], a[31:24], a[39:32], a[47:40]};
  endfunction

  function automatic logic [31:0] hi_word(input logic [47:0] a);
    return {16'h0000, a[7:0], a[15:8]};
  endfunction

  task automatic raw_write(input int idx, input bit hi_sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi_sel; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi_sel) begin
      m_addr[idx] = {m_stage[idx][7:0], m_stage[idx][15:8], m_stage[idx][23:16],
                     m_stage[idx][31:24], d[7:0], d[15:8]};
      m_valid[idx] = (m_addr[idx] != 48'h0);
    end else begin
      m_stage[idx] = d;
    end
  endtask

  task automatic write_entry(input int idx, input logic [47:0] a);
    raw_write(idx, 1'b0, lo_word(a));
    raw_write(idx, 1'b1, hi_word(a) | 32'hFFFF_0000);
  endtask

  task automatic do_init(input logic [47:0] s);
    @(negedge clk);
    station = s; init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_addr[i] = '0; m_valid[i] = 1'b0; m_stage[i] = '0;
    end
    m_addr[0] = s; m_valid[0] = (s != 48'h0);
  endtask

  task automatic check_cmp(input logic [47:0] a, input string req);
    logic exp_hit;
    logic [IW-1:0] exp_idx;
    exp_hit = 1'b0; exp_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_valid[i] && m_addr[i] == a) begin exp_hit = 1'b1; exp_idx = IW'(i); end
    @(negedge clk);
    cmp_valid = 1'b1; cmp_addr = a;
    @(negedge clk);
    cmp_valid = 1'b0;
    check(req, {hit_valid, hit, hit_idx}, {1'b1, exp_hit, exp_idx});
  endtask

  task automatic run_alt(input bit f1);
    rd_cnt = 0;
    @(negedge clk);
    alt_start = 1'b1; alt_func1 = f1;
    @(negedge clk);
    alt_start = 1'b0;
    for (int t = 0; t < 200 && !alt_done; t++) @(negedge clk);
    check("R11 loader done", {63'h0, alt_done}, 64'h1);
    @(negedge clk);
  endtask

  localparam logic [47:0] STA  = 48'h00_1B_21_0A_0B_0C;
  localparam logic [47:0] ALT0 = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] ALT1 = 48'h06_11_22_33_44_55;
  localparam logic [47:0] MCA  = 48'h03_AA_BB_CC_DD_EE;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    for (int i = 0; i < N; i++) begin m_addr[i] = '0; m_valid[i] = 1'b0; m_stage[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset outputs", {60'h0, hit_valid, hit, nvm_req, alt_done}, 64'h0);

    do_init(STA);
    check_cmp(STA, "R5 station in entry 0");
    check_cmp(48'h0, "R3 zero address never hits");
    check_cmp(48'h00_1B_21_0A_0B_0D, "R6 miss gives idx 0");
    @(negedge clk);
    check("R6 no result without strobe", {63'h0, hit_valid}, 64'h0);

    // R1 R2: hand-built words
    raw_write(5, 1'b0, 32'h3322_1102);
    raw_write(5, 1'b1, 32'hABCD_5544);
    check_cmp(48'h02_11_22_33_44_55, "R1 R2 byte placement");

    // R4: staged low word invisible until high write
    raw_write(5, 1'b0, lo_word(48'h0A_0B_0C_0D_44_55));
    check_cmp(48'h02_11_22_33_44_55, "R4 old address still live");
    check_cmp(48'h0A_0B_0C_0D_44_55, "R4 staged address not live");
    raw_write(5, 1'b1, 32'h0000_5544);
    check_cmp(48'h0A_0B_0C_0D_44_55, "R4 commit on high write");

    // R3: zeroing a live entry makes it invalid
    raw_write(5, 1'b0, 32'h0);
    raw_write(5, 1'b1, 32'h8000_0000);
    check_cmp(48'h0A_0B_0C_0D_44_55, "R3 zeroed entry gone");
    check_cmp(48'h0, "R3 zero entry no hit");

    // R7: duplicates
    write_entry(9, 48'h12_34_56_78_9A_BC);
    write_entry(3, 48'h12_34_56_78_9A_BC);
    check_cmp(48'h12_34_56_78_9A_BC, "R7 lowest index wins");

    // R5: init empties others
    do_init(STA);
    check_cmp(48'h12_34_56_78_9A_BC, "R5 other entries cleared");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      int idx;
      logic [47:0] a;
      op  = $urandom_range(0, 9);
      idx = $urandom_range(0, N - 1);
      a   = {16'($urandom), $urandom};
      if ($urandom_range(0, 7) == 0) a = '0;
      if (op < 3) begin
        if ($urandom_range(0, 3) == 0) a = m_addr[$urandom_range(0, N - 1)];
        write_entry(idx, a);
      end else if (op == 3) begin
        raw_write(idx, $urandom_range(0, 1) == 1, $urandom);
      end else begin
        if ($urandom_range(0, 3) != 0) a = m_addr[$urandom_range(0, N - 1)];
        check_cmp(a, "R7 R3 R4 random compare");
      end
    end

    // alternate address loads
    do_init(STA);
    mem[PTR] = 16'hFFFF;
    run_alt(1'b0);
    check_cmp(STA, "R8 pointer FFFF keeps entry 0");
    check("R8 pointer read address", {48'h0, rd_log[0]}, {48'h0, PTR});
    check("R8 single read", 64'(rd_cnt), 64'd1);

    mem[PTR] = 16'h0000;
    run_alt(1'b0);
    check_cmp(STA, "R8 pointer 0000 keeps entry 0");

    mem[PTR] = 16'h0010;
    mem[16'h10] = 16'hAA02; mem[16'h11] = 16'hCCBB; mem[16'h12] = 16'hEEDD;
    mem[16'h13] = 16'h1106; mem[16'h14] = 16'h3322; mem[16'h15] = 16'h5544;
    run_alt(1'b0);
    m_addr[0] = ALT0; m_valid[0] = 1'b1;
    check_cmp(ALT0, "R9 alternate replaces entry 0");
    check_cmp(STA, "R9 station gone");
    check("R9 word addresses", {16'h0, rd_log[1], rd_log[2], rd_log[3]},
          {16'h0, 16'h0010, 16'h0011, 16'h0012});

    do_init(STA);
    run_alt(1'b1);
    m_addr[0] = ALT1; m_valid[0] = 1'b1;
    check_cmp(ALT1, "R9 second port offset");
    check("R11 offset addresses", {16'h0, rd_log[1], rd_log[2], rd_log[3]},
          {16'h0, 16'h0013, 16'h0014, 16'h0015});

    do_init(STA);
    mem[PTR] = 16'h0020;
    mem[16'h20] = 16'hAA03; mem[16'h21] = 16'hCCBB; mem[16'h22] = 16'hEEDD;
    run_alt(1'b0);
    check_cmp(STA, "R10 multicast alternate rejected");
    check_cmp(MCA, "R10 multicast not loaded");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule